// File: doc/BRIEF.md
# Early-Write External Bus Cycle Sequencer

This block turns internal write requests into early-write transactions on an external 16-bit memory or I/O bus. The byte write strobes go active in the first clock of the cycle, before the data bus is driven and before the chip-select falls. A memory wired this way never needs the read strobe to qualify a write. Each request carries an address, write data, two byte enables and a zone configuration made of a wait count and a hold count. The wait count stretches the strobe phase. The hold count keeps the address and data on the bus after the strobes are released.

A request is taken only while the sequencer is idle. A write runs T1, zero to three wait states, T2, T3 and zero to three hold cycles. A `done` pulse marks the last clock of each transaction. A minimal two-clock read cycle is also present. Its only purpose is the bus turnaround rule: a read that directly follows an early write gets one extra idle clock first. Early-write cycles are enabled by a configuration input. While that input is low, write requests are refused.

Top module: `ewbus_seq`

## Requirements
- R1: After reset the sequencer is idle. `wr_n` is 2'b11, `cs_n` and `rd_n` are 1, `bus_doe` is 0, `done` is 0, and `req_ready` is 1.
- R2: While `early_en` is 0, a write request (`req_write`=1) sees `req_ready`=0 and is not taken. The bus stays idle: strobes and chip-select inactive, data not driven.
- R3: A write is taken on a clock where `req_valid` and `req_ready` are both 1. The next clock is T1. In T1, `bus_addr` carries the request address, `bus_doe`=0, `rd_n`=1 and `cs_n`=1, and the byte write strobes are active.
- R4: After T1 there are exactly `req_wait` wait clocks (0 to 3), followed by one T2 clock. Through every wait clock and T2, `bus_doe`=1, `bus_dout` carries the write data, `cs_n`=0 and the enabled strobes stay active.
- R5: The strobes are active low and follow the byte enables. `wr_n[0]` serves byte enable bit 0 (data bits 7:0) and `wr_n[1]` serves bit 1 (data bits 15:8). A strobe whose enable is 0 stays high.
- R6: The clock after T2 is T3. In T3, `cs_n`=1, `wr_n`=2'b11 and the address is unchanged. `bus_doe` is 1 in T3 only when the hold count is nonzero.
- R7: After T3 there are exactly `req_hold` hold clocks (0 to 3). In each hold clock the address and data stay driven (`bus_doe`=1) and the strobes and chip-select are inactive. `bus_doe` is 0 in the clock that follows the write.
- R8: `done` is high for exactly one clock, the last clock of the transaction. For a write that is T3 when the hold count is 0, or else the last hold clock. For a read it is the second read clock.
- R9: The address, data, byte enables, wait count and hold count are sampled when the request is taken. Changing those inputs during the transaction has no effect on it.
- R10: A read runs two clocks. In both, `rd_n`=0, `cs_n`=0, `wr_n`=2'b11, `bus_doe`=0, and `bus_addr` carries the read address. `rdata` takes the value on `bus_din` at the end of the second clock.
- R11: Suppose a read is taken in the first idle clock after an early write ends. The sequencer then spends one clock with all strobes, the chip-select and the data drive inactive, and `req_ready`=0, before the first read clock. A read taken at any other time starts in the clock after it is taken.
- R12: `req_ready` is 0 in every clock of a transaction, including the turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| early_en | input | 1 | Configuration enable for early-write cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wait | input | 2 | Zone wait count |
| req_hold | input | 2 | Zone hold count |
| req_ready | output | 1 | Request can be taken this clock |
| done | output | 1 | Last clock of the transaction |
| rdata | output | 16 | Data captured by the last read |
| bus_addr | output | 16 | External address bus |
| bus_dout | output | 16 | External data bus, output value |
| bus_doe | output | 1 | Data bus drive enable, 0 = high impedance |
| bus_din | input | 16 | External data bus, input value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 2 | Byte write strobes, active low |
| cs_n | output | 1 | Chip-select, active low |

## Verification
The bench covers the zero and maximum wait and hold counts. A design that miscounts either would lengthen or shorten the cycle and push every later expected clock out of step. It checks the drive enable in T3 with and without hold cycles. A design that drops the data too early, or keeps it one clock too long, would show a wrong `bus_doe` in T3 or in the following idle clock. Single-byte writes on each lane, and configuration inputs changed during a transaction, expose swapped strobes and configuration that is not latched. A read is issued right after a write, and again after a gap. A missing or unconditional turnaround clock moves the read strobe one clock away from where it is expected.

// File: rtl/ewbus_pkg.sv
package ewbus_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_T1,
      S_WAIT,
      S_T2,
      S_T3,
      S_HOLD,
      S_TURN,
      S_R1,
      S_R2
   } seq_state_t;

endpackage

// File: rtl/ewbus_capture.sv
module ewbus_capture #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   parameter int WAIT_W = 2,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LANES-1:0]  in_be,
   input  logic [WAIT_W-1:0] in_wait,
   input  logic [HOLD_W-1:0] in_hold,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data,
   output logic [LANES-1:0]  cap_be,
   output logic [WAIT_W-1:0] cap_wait,
   output logic [HOLD_W-1:0] cap_hold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_data <= '0;
         cap_be   <= '0;
         cap_wait <= '0;
         cap_hold <= '0;
      end else if (load) begin
         cap_addr <= in_addr;
         cap_data <= in_data;
         cap_be   <= in_be;
         cap_wait <= in_wait;
         cap_hold <= in_hold;
      end
   end

endmodule

// File: rtl/ewbus_ctrl.sv
module ewbus_ctrl
   import ewbus_pkg::*;
#(
   parameter int WAIT_W = 2,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              early_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [WAIT_W-1:0] cap_wait,
   input  logic [HOLD_W-1:0] cap_hold,
   output seq_state_t        state,
   output logic              accept,
   output logic              req_ready,
   output logic              done
);

   localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

   seq_state_t       nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             tail, tail_nxt;
   logic             last_clk;

   assign req_ready = (state == S_IDLE) && (early_en || !req_write);
   assign accept    = req_valid && req_ready;

   always_comb begin
      last_clk = 1'b0;
      case (state)
         S_T3:    last_clk = (cap_hold == '0);
         S_HOLD:  last_clk = (cnt == '0);
         S_R2:    last_clk = 1'b1;
         default: last_clk = 1'b0;
      endcase
   end

   assign done = last_clk;

   always_comb begin
      nxt     = state;
      cnt_nxt = cnt;
      case (state)
         S_IDLE: begin
            if (accept) begin
               if (req_write)  nxt = S_T1;
               else if (tail)  nxt = S_TURN;
               else            nxt = S_R1;
            end
         end
         S_T1: begin
            cnt_nxt = CNT_W'(cap_wait) - CNT_W'(1);
            nxt     = (cap_wait != '0) ? S_WAIT : S_T2;
         end
         S_WAIT: begin
            cnt_nxt = cnt - CNT_W'(1);
            nxt     = (cnt == '0) ? S_T2 : S_WAIT;
         end
         S_T2: nxt = S_T3;
         S_T3: begin
            cnt_nxt = CNT_W'(cap_hold) - CNT_W'(1);
            nxt     = (cap_hold != '0) ? S_HOLD : S_IDLE;
         end
         S_HOLD: begin
            cnt_nxt = cnt - CNT_W'(1);
            nxt     = (cnt == '0) ? S_IDLE : S_HOLD;
         end
         S_TURN:  nxt = S_R1;
         S_R1:    nxt = S_R2;
         S_R2:    nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_comb begin
      tail_nxt = tail;
      if (state == S_IDLE)
         tail_nxt = 1'b0;
      if (last_clk && (state != S_R2))
         tail_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         tail  <= 1'b0;
      end else begin
         state <= nxt;
         cnt   <= cnt_nxt;
         tail  <= tail_nxt;
      end
   end

endmodule

// File: rtl/ewbus_drive.sv
module ewbus_drive
   import ewbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [LANES-1:0]  cap_be,
   input  logic [HOLD_W-1:0] cap_hold,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic              rd_n,
   output logic [LANES-1:0]  wr_n,
   output logic              cs_n,
   output logic [DATA_W-1:0] rdata
);

   logic strobe_phase;
   logic select_phase;
   logic read_phase;
   logic data_phase;

   assign strobe_phase = (state == S_T1) || (state == S_WAIT) || (state == S_T2);
   assign read_phase   = (state == S_R1) || (state == S_R2);
   assign select_phase = (state == S_WAIT) || (state == S_T2) || read_phase;
   assign data_phase   = (state == S_WAIT) || (state == S_T2) || (state == S_HOLD) ||
                         ((state == S_T3) && (cap_hold != '0));

   assign bus_addr = cap_addr;
   assign bus_dout = cap_data;
   assign bus_doe  = data_phase;
   assign rd_n     = !read_phase;
   assign cs_n     = !select_phase;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wr_n[g] = !(strobe_phase && cap_be[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (state == S_R2)
         rdata <= bus_din;
   end

endmodule

// File: rtl/ewbus_seq.sv
module ewbus_seq
   import ewbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int WAIT_W = 2,
   parameter int HOLD_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                early_en,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [WAIT_W-1:0]   req_wait,
   input  logic [HOLD_W-1:0]   req_hold,
   output logic                req_ready,
   output logic                done,
   output logic [DATA_W-1:0]   rdata,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]   bus_dout,
   output logic                bus_doe,
   input  logic [DATA_W-1:0]   bus_din,
   output logic                rd_n,
   output logic [DATA_W/8-1:0] wr_n,
   output logic                cs_n
);

   localparam int LANES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("ewbus_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ewbus_seq: ADDR_W must be at least 1");
   end
   if (WAIT_W < 1 || HOLD_W < 1) begin : g_bad_cfg_w
      $error("ewbus_seq: WAIT_W and HOLD_W must be at least 1");
   end

   seq_state_t        state;
   logic              accept;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [LANES-1:0]  cap_be;
   logic [WAIT_W-1:0] cap_wait;
   logic [HOLD_W-1:0] cap_hold;

   ewbus_capture #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
      .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .in_addr  (req_addr),
      .in_data  (req_wdata),
      .in_be    (req_be),
      .in_wait  (req_wait),
      .in_hold  (req_hold),
      .cap_addr (cap_addr),
      .cap_data (cap_data),
      .cap_be   (cap_be),
      .cap_wait (cap_wait),
      .cap_hold (cap_hold)
   );

   ewbus_ctrl #(
      .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .early_en  (early_en),
      .req_valid (req_valid),
      .req_write (req_write),
      .cap_wait  (cap_wait),
      .cap_hold  (cap_hold),
      .state     (state),
      .accept    (accept),
      .req_ready (req_ready),
      .done      (done)
   );

   ewbus_drive #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .HOLD_W(HOLD_W)
   ) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .cap_addr (cap_addr),
      .cap_data (cap_data),
      .cap_be   (cap_be),
      .cap_hold (cap_hold),
      .bus_din  (bus_din),
      .bus_addr (bus_addr),
      .bus_dout (bus_dout),
      .bus_doe  (bus_doe),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .cs_n     (cs_n),
      .rdata    (rdata)
   );

endmodule

// File: rtl/ewbus_chk.sv
module ewbus_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                done,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_dout,
   input logic                bus_doe,
   input logic                rd_n,
   input logic [DATA_W/8-1:0] wr_n,
   input logic                cs_n
);

   // R3: no write strobe while the read strobe is active
   p_no_rd_with_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n != '1) |-> rd_n);

   // R4: chip-select in a write cycle always comes with driven data
   p_cs_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rd_n) |-> bus_doe);

   // R6: address does not move while the write select is active
   p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rd_n) |-> $stable(bus_addr));

   // R7: address and data stay put while data is driven
   p_data_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> ($stable(bus_addr) && $stable(bus_dout)));

   // R8: completion lasts one clock and leaves the bus quiet
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && cs_n && rd_n && (wr_n == '1)));

   // R10: data bus never driven during a read
   p_rd_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !bus_doe);

   // R12: no new request taken while any strobe is active
   p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_n != '1) || !rd_n || !cs_n || bus_doe) |-> !req_ready);

endmodule

bind ewbus_seq ewbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ewbus_seq_test.sv
module ewbus_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        early_en = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic [1:0]  req_wait = '0;
   logic [1:0]  req_hold = '0;
   logic        req_ready;
   logic        done;
   logic [15:0] rdata;
   logic [15:0] bus_addr;
   logic [15:0] bus_dout;
   logic        bus_doe;
   logic [15:0] bus_din = '0;
   logic        rd_n;
   logic [1:0]  wr_n;
   logic        cs_n;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   ewbus_seq uut (
      .clk(clk), .rst_n(rst_n), .early_en(early_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_wait(req_wait),
      .req_hold(req_hold), .req_ready(req_ready), .done(done),
      .rdata(rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n),
      .cs_n(cs_n)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          at;
      string       tag;
      logic        chk_addr;
      logic [15:0] addr;
      logic        oe;
      logic [15:0] dout;
      logic        rd;
      logic [1:0]  wr;
      logic        cs;
      logic        dn;
      logic        rdy;
      logic        chk_rd;
      logic [15:0] rdat;
   } exp_t;

   exp_t sb[$];

   function automatic exp_t quiet(int at, string tag, logic rdy);
      exp_t e;
      e.at = at; e.tag = tag; e.chk_addr = 1'b0; e.addr = '0;
      e.oe = 1'b0; e.dout = '0; e.rd = 1'b1; e.wr = 2'b11; e.cs = 1'b1;
      e.dn = 1'b0; e.rdy = rdy; e.chk_rd = 1'b0; e.rdat = '0;
      return e;
   endfunction

   task automatic note(bit ok, string tag, string msg);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s", tag, msg);
      end
   endtask

   // monitor: compares each expected item on its clock
   always @(negedge clk) begin
      if (rst_n) begin
         while (sb.size() > 0 && sb[0].at < cyc) begin
            note(1'b0, sb[0].tag, $sformatf("item for cycle %0d never compared (now %0d)", sb[0].at, cyc));
            void'(sb.pop_front());
         end
         if (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            ok = (bus_doe == e.oe) && (rd_n == e.rd) && (wr_n == e.wr) &&
                 (cs_n == e.cs) && (done == e.dn) && (req_ready == e.rdy);
            if (e.chk_addr && bus_addr != e.addr) ok = 0;
            if (e.oe && bus_dout != e.dout) ok = 0;
            if (e.chk_rd && rdata != e.rdat) ok = 0;
            note(ok, e.tag, $sformatf(
               "cyc %0d actual addr=%h oe=%b dout=%h rd=%b wr=%b cs=%b done=%b rdy=%b rdata=%h expected addr=%h oe=%b dout=%h rd=%b wr=%b cs=%b done=%b rdy=%b rdata=%h",
               cyc, bus_addr, bus_doe, bus_dout, rd_n, wr_n, cs_n, done, req_ready, rdata,
               e.addr, e.oe, e.dout, e.rd, e.wr, e.cs, e.dn, e.rdy, e.rdat));
         end
      end
   end

   // driver: write, returns on the negedge of the first idle clock after it
   task automatic do_write(logic [15:0] a, logic [15:0] d, logic [1:0] be,
                           int w, int h, bit scramble);
      int   c0;
      exp_t e;
      #2;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      req_be = be; req_wait = 2'(w); req_hold = 2'(h);
      #1;
      note(req_ready == 1'b1, "R3", $sformatf("ready actual %b expected 1", req_ready));
      c0 = cyc;
      e = quiet(c0 + 1, "R3", 1'b0);
      e.chk_addr = 1; e.addr = a; e.wr = ~be;
      sb.push_back(e);
      for (int k = 0; k < w; k++) begin
         e = quiet(c0 + 2 + k, "R4", 1'b0);
         e.chk_addr = 1; e.addr = a; e.oe = 1; e.dout = d; e.wr = ~be; e.cs = 0;
         sb.push_back(e);
      end
      e = quiet(c0 + 2 + w, "R5", 1'b0);
      e.chk_addr = 1; e.addr = a; e.oe = 1; e.dout = d; e.wr = ~be; e.cs = 0;
      sb.push_back(e);
      e = quiet(c0 + 3 + w, "R6", 1'b0);
      e.chk_addr = 1; e.addr = a; e.oe = (h != 0); e.dout = d; e.dn = (h == 0);
      sb.push_back(e);
      for (int k = 0; k < h; k++) begin
         e = quiet(c0 + 4 + w + k, "R7", 1'b0);
         e.chk_addr = 1; e.addr = a; e.oe = 1; e.dout = d; e.dn = (k == h - 1);
         sb.push_back(e);
      end
      sb.push_back(quiet(c0 + 4 + w + h, "R8", 1'b1));
      @(negedge clk);
      #2;
      req_valid = 1'b0;
      if (scramble) begin
         // R9: inputs changed mid-transaction must not matter
         req_addr = ~a; req_wdata = ~d; req_be = ~be;
         req_wait = 2'(3 - w); req_hold = 2'(3 - h);
      end
      while (cyc < c0 + 4 + w + h) @(negedge clk);
   endtask

   // driver: read, returns on the negedge of the idle clock after it
   task automatic do_read(logic [15:0] a, logic [15:0] din, bit turn);
      int   c0;
      int   r1;
      exp_t e;
      #2;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; bus_din = din;
      #1;
      note(req_ready == 1'b1, "R10", $sformatf("ready actual %b expected 1", req_ready));
      c0 = cyc;
      r1 = turn ? c0 + 2 : c0 + 1;
      if (turn) sb.push_back(quiet(c0 + 1, "R11", 1'b0));
      e = quiet(r1, turn ? "R11" : "R10", 1'b0);
      e.chk_addr = 1; e.addr = a; e.rd = 0; e.cs = 0;
      sb.push_back(e);
      e = quiet(r1 + 1, "R10", 1'b0);
      e.chk_addr = 1; e.addr = a; e.rd = 0; e.cs = 0; e.dn = 1;
      sb.push_back(e);
      e = quiet(r1 + 2, "R10", 1'b1);
      e.chk_rd = 1; e.rdat = din;
      sb.push_back(e);
      @(negedge clk);
      #2;
      req_valid = 1'b0;
      while (cyc < r1 + 2) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      note(wr_n == 2'b11 && cs_n && rd_n && !bus_doe && !done && req_ready, "R1",
           $sformatf("reset actual wr=%b cs=%b rd=%b oe=%b done=%b rdy=%b expected 11 1 1 0 0 1",
                     wr_n, cs_n, rd_n, bus_doe, done, req_ready));
      rst_n = 1'b1;
      @(negedge clk);

      // R2: write refused while early-write is disabled
      early_en = 1'b0;
      #2;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_be = 2'b11;
      #1;
      note(req_ready == 1'b0, "R2", $sformatf("ready actual %b expected 0", req_ready));
      repeat (3) begin
         @(negedge clk);
         note(wr_n == 2'b11 && cs_n && rd_n && !bus_doe, "R2",
              $sformatf("bus actual wr=%b cs=%b rd=%b oe=%b expected 11 1 1 0",
                        wr_n, cs_n, rd_n, bus_doe));
      end
      #2;
      req_valid = 1'b0;
      early_en = 1'b1;
      @(negedge clk);
      @(negedge clk);

      do_write(16'hA001, 16'h5AA5, 2'b11, 0, 0, 0);
      repeat (2) @(negedge clk);
      do_write(16'hB002, 16'h1357, 2'b01, 3, 3, 1);
      do_write(16'hC003, 16'h2468, 2'b10, 1, 2, 1);
      do_write(16'hD004, 16'h0F0F, 2'b11, 2, 0, 0);
      do_read(16'hE005, 16'hCAFE, 1);
      repeat (2) @(negedge clk);
      do_read(16'hF006, 16'hBEEF, 0);
      do_read(16'h0107, 16'h7711, 0);
      do_write(16'h0208, 16'h8421, 2'b10, 0, 3, 0);
      repeat (1) @(negedge clk);
      do_read(16'h0309, 16'h3C3C, 0);
      do_write(16'h040A, 16'h9999, 2'b01, 3, 1, 0);
      do_read(16'h050B, 16'h6006, 1);

      repeat (3) @(negedge clk);
      if (sb.size() != 0)
         note(1'b0, "R8", $sformatf("left over items actual %0d expected 0", sb.size()));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule